// File: doc/BRIEF.md
# Frame Decision-Tree Speech Classifier

This block labels each audio frame as speech or non-speech. It uses a small binary decision tree that is evaluated fully in hardware. Once per frame, a strobe presents eight digitized band-energy features. Every tree node picks one of those features, compares it with its own trained threshold, and may invert the result. The block computes all node decisions in parallel. It then follows the path from the root to a leaf. The class bit programmed for that leaf becomes the frame result, which is presented one clock later together with a valid strobe.

A host programs the tree over a simple write-only register bus. Each node address holds a threshold, a feature select and an invert bit. One further address holds the class bits of all leaves. Training and threshold generation happen elsewhere. The block only applies the configuration it is given. A write that arrives in the same cycle as a frame strobe takes effect from the following frame.

The default tree has three levels of decision nodes (seven nodes) and eight leaves. Node widths, feature count and depth are parameters.

Top module: `dtc_classifier`

## Requirements
- R1: After reset, `valid_o` and `class_o` are 0. Every threshold, select, invert bit and leaf class bit is 0, so a frame evaluated before any write yields class 0.
- R2: `valid_o` is 1 in exactly the cycle after a cycle in which `frame_i` was 1, and is 0 in every other cycle.
- R3: A node's raw result is 1 only when its selected feature is strictly greater than its threshold (unsigned). A feature equal to the threshold gives 0.
- R4: When a node's invert bit is set, its decision is the complement of the raw result from R3.
- R5: A select value k (0 to 7) makes the node use feature k, taken from `feat_i[8k+7:8k]`.
- R6: Nodes are numbered in heap order, with node 0 as the root and nodes 2i+1 and 2i+2 as the children of node i. A decision of 1 moves to the right child. The leaf index is the three path decisions, with the root decision as the most significant bit. `class_o` takes the class bit of that leaf.
- R7: A write to address i (0 to 6) sets node i, with threshold in data bits [7:0], select in [10:8] and invert in [11]. A write to address 7 sets leaf class bits, with bit j in data bit j (j = 0 to 7).
- R8: A configuration write in the same cycle as `frame_i` does not change that frame's result. It applies from the next frame.
- R9: Between frames, `class_o` holds the last result, whatever the changes on `feat_i` or the configuration writes.
- R10: Features and decisions of nodes off the taken path have no effect on `class_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write enable |
| wr_addr_i | input | 3 | Configuration address (node 0 to 6, leaf classes at 7) |
| wr_data_i | input | 12 | Configuration write data |
| frame_i | input | 1 | Frame strobe; features are evaluated at this edge |
| feat_i | input | 64 | Eight 8-bit features, feature k in bits [8k+7:8k] |
| valid_o | output | 1 | Result strobe, one cycle after the frame strobe |
| class_o | output | 1 | Class of the last evaluated frame (1 = speech) |

## Verification
A wrong stored threshold, select or invert bit does not show at once. It appears only at the next frame whose path passes through that node, as a wrong `class_o` one clock after the strobe. Feature patterns are therefore chosen so that each vector steers a different path and lands exactly on a threshold at some nodes. A corrupted leaf class bit shows only when its leaf is reached. The bench drives frames that reach every leaf class value and checks ordering races with a write and a frame in the same cycle. A fault in the output registers shows as a `valid_o` pulse that is missing or too long, or as a `class_o` that drifts between strobes, in the cycle after the fault.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

   localparam int DEF_FEAT_W = 8;
   localparam int DEF_N_FEAT = 8;
   localparam int DEF_LEVELS = 3;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dtc_cfg_bank.sv
module dtc_cfg_bank #(
   parameter int FEAT_W = 8,
   parameter int SEL_W  = 3,
   parameter int NODES  = 7,
   parameter int LEAVES = 8,
   parameter int ADDR_W = 3,
   parameter int DATA_W = 12
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_en_i,
   input  logic [ADDR_W-1:0]        wr_addr_i,
   input  logic [DATA_W-1:0]        wr_data_i,
   output logic [NODES*FEAT_W-1:0]  thr_o,
   output logic [NODES*SEL_W-1:0]   sel_o,
   output logic [NODES-1:0]         inv_o,
   output logic [LEAVES-1:0]        leaf_o
);

   localparam int INV_POS = FEAT_W + SEL_W;

   logic unused_data;
   assign unused_data = ^wr_data_i;

   for (genvar n = 0; n < NODES; n++) begin : g_node_reg
      logic hit;
      logic [FEAT_W-1:0] thr_q;
      logic [SEL_W-1:0]  sel_q;
      logic              inv_q;

      assign hit = wr_en_i && (wr_addr_i == ADDR_W'(n));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            thr_q <= '0;
            sel_q <= '0;
            inv_q <= 1'b0;
         end else if (hit) begin
            thr_q <= wr_data_i[FEAT_W-1:0];
            sel_q <= wr_data_i[FEAT_W +: SEL_W];
            inv_q <= wr_data_i[INV_POS];
         end
      end

      assign thr_o[n*FEAT_W +: FEAT_W] = thr_q;
      assign sel_o[n*SEL_W +: SEL_W]   = sel_q;
      assign inv_o[n]                  = inv_q;
   end

   logic leaf_hit;
   logic [LEAVES-1:0] leaf_q;

   assign leaf_hit = wr_en_i && (wr_addr_i == ADDR_W'(NODES));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         leaf_q <= '0;
      end else if (leaf_hit) begin
         leaf_q <= wr_data_i[LEAVES-1:0];
      end
   end

   assign leaf_o = leaf_q;

endmodule

// File: rtl/dtc_node.sv
module dtc_node #(
   parameter int FEAT_W = 8,
   parameter int N_FEAT = 8,
   parameter int SEL_W  = 3
) (
   input  logic [N_FEAT*FEAT_W-1:0] feat_i,
   input  logic [SEL_W-1:0]         sel_i,
   input  logic [FEAT_W-1:0]        thr_i,
   input  logic                     inv_i,
   output logic [FEAT_W-1:0]        pick_o,
   output logic                     dec_o
);

   logic [FEAT_W-1:0] pick;
   logic              above;

   always_comb begin
      pick = '0;
      for (int k = 0; k < N_FEAT; k++) begin
         if (sel_i == SEL_W'(k)) begin
            pick = feat_i[k*FEAT_W +: FEAT_W];
         end
      end
   end

   assign above  = (pick > thr_i);
   assign dec_o  = above ^ inv_i;
   assign pick_o = pick;

endmodule

// File: rtl/dtc_path.sv
module dtc_path #(
   parameter int LEVELS = 3,
   parameter int NODES  = 7,
   parameter int LEAVES = 8
) (
   input  logic [NODES-1:0]  dec_i,
   input  logic [LEAVES-1:0] leaf_i,
   output logic [LEVELS-1:0] leaf_idx_o,
   output logic              class_o
);

   localparam int NODE_W = $clog2(NODES);

   logic [LEVELS-1:0] pos;
   logic [NODE_W-1:0] node;

   always_comb begin
      pos  = '0;
      node = '0;
      for (int l = 0; l < LEVELS; l++) begin
         node = NODE_W'((1 << l) - 1) + NODE_W'(pos);
         pos  = {pos[LEVELS-2:0], dec_i[node]};
      end
   end

   assign leaf_idx_o = pos;
   assign class_o    = leaf_i[pos];

endmodule

// File: rtl/dtc_classifier.sv
module dtc_classifier #(
   parameter int  FEAT_W = dtc_pkg::DEF_FEAT_W,
   parameter int  N_FEAT = dtc_pkg::DEF_N_FEAT,
   parameter int  LEVELS = dtc_pkg::DEF_LEVELS,
   localparam int NODES  = (1 << LEVELS) - 1,
   localparam int LEAVES = 1 << LEVELS,
   localparam int SEL_W  = $clog2(N_FEAT),
   localparam int CFG_W  = FEAT_W + SEL_W + 1,
   localparam int DATA_W = dtc_pkg::max2(CFG_W, LEAVES),
   localparam int ADDR_W = $clog2(NODES + 1)
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     wr_en_i,
   input  logic [ADDR_W-1:0]        wr_addr_i,
   input  logic [DATA_W-1:0]        wr_data_i,
   input  logic                     frame_i,
   input  logic [N_FEAT*FEAT_W-1:0] feat_i,
   output logic                     valid_o,
   output logic                     class_o
);

   if (LEVELS < 2) begin : g_bad_levels
      $error("dtc_classifier: LEVELS must be at least 2");
   end
   if (FEAT_W < 1) begin : g_bad_width
      $error("dtc_classifier: FEAT_W must be positive");
   end
   if (!dtc_pkg::is_pow2(N_FEAT) || N_FEAT < 2) begin : g_bad_nfeat
      $error("dtc_classifier: N_FEAT must be a power of two, at least 2");
   end

   logic [NODES*FEAT_W-1:0] thr_flat;
   logic [NODES*SEL_W-1:0]  sel_flat;
   logic [NODES-1:0]        inv_vec;
   logic [LEAVES-1:0]       leaf_q;
   logic [NODES*FEAT_W-1:0] node_feat;
   logic [NODES-1:0]        node_dec;
   logic [LEVELS-1:0]       leaf_idx;
   logic                    cls_next;

   dtc_cfg_bank #(
      .FEAT_W (FEAT_W),
      .SEL_W  (SEL_W),
      .NODES  (NODES),
      .LEAVES (LEAVES),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_addr_i (wr_addr_i),
      .wr_data_i (wr_data_i),
      .thr_o     (thr_flat),
      .sel_o     (sel_flat),
      .inv_o     (inv_vec),
      .leaf_o    (leaf_q)
   );

   for (genvar n = 0; n < NODES; n++) begin : g_nodes
      dtc_node #(
         .FEAT_W (FEAT_W),
         .N_FEAT (N_FEAT),
         .SEL_W  (SEL_W)
      ) u_node (
         .feat_i (feat_i),
         .sel_i  (sel_flat[n*SEL_W +: SEL_W]),
         .thr_i  (thr_flat[n*FEAT_W +: FEAT_W]),
         .inv_i  (inv_vec[n]),
         .pick_o (node_feat[n*FEAT_W +: FEAT_W]),
         .dec_o  (node_dec[n])
      );
   end

   dtc_path #(
      .LEVELS (LEVELS),
      .NODES  (NODES),
      .LEAVES (LEAVES)
   ) u_path (
      .dec_i      (node_dec),
      .leaf_i     (leaf_q),
      .leaf_idx_o (leaf_idx),
      .class_o    (cls_next)
   );

   logic valid_q;
   logic class_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_q <= 1'b0;
         class_q <= 1'b0;
      end else begin
         valid_q <= frame_i;
         if (frame_i) begin
            class_q <= cls_next;
         end
      end
   end

   assign valid_o = valid_q;
   assign class_o = class_q;

   logic unused_idx;
   assign unused_idx = ^leaf_idx;

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
   parameter int NODES  = 7,
   parameter int LEAVES = 8,
   parameter int FEAT_W = 8
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic                    frame_i,
   input logic                    valid_o,
   input logic                    class_o,
   input logic [LEAVES-1:0]       leaf_cls,
   input logic [NODES-1:0]        node_dec,
   input logic [NODES*FEAT_W-1:0] node_feat,
   input logic [NODES*FEAT_W-1:0] node_thr,
   input logic [NODES-1:0]        node_inv
);

   // R2
   frame_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_i |=> valid_o);

   // R2
   idle_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_i |=> !valid_o);

   // R9
   class_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_i |=> $stable(class_o));

   // R6
   all_leaf_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_i && (&leaf_cls)) |=> class_o);

   // R6
   all_leaf_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_i && !(|leaf_cls)) |=> !class_o);

   for (genvar n = 0; n < NODES; n++) begin : g_node_chk
      // R3 R4
      tie_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (node_feat[n*FEAT_W +: FEAT_W] == node_thr[n*FEAT_W +: FEAT_W])
            |-> (node_dec[n] == node_inv[n]));

      // R3
      zero_feat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (node_feat[n*FEAT_W +: FEAT_W] == '0) |-> (node_dec[n] == node_inv[n]));
   end

endmodule

bind dtc_classifier dtc_checker #(
   .NODES  (NODES),
   .LEAVES (LEAVES),
   .FEAT_W (FEAT_W)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .frame_i   (frame_i),
   .valid_o   (valid_o),
   .class_o   (class_o),
   .leaf_cls  (leaf_q),
   .node_dec  (node_dec),
   .node_feat (node_feat),
   .node_thr  (thr_flat),
   .node_inv  (inv_vec)
);

// File: tb/sim_dtc_classifier.sv
module sim_dtc_classifier;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [2:0]  wr_addr;
   logic [11:0] wr_data;
   logic        frame;
   logic [63:0] feat;
   logic        valid;
   logic        cls;

   int compared   = 0;
   int mismatched = 0;
   bit done       = 1'b0;

   always #5 clk = ~clk;

   dtc_classifier u0 (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data),
      .frame_i   (frame),
      .feat_i    (feat),
      .valid_o   (valid),
      .class_o   (cls)
   );

   // Features written f7 first; expectations follow R3 R4 R5 R6 under config A.
   localparam int NV = 9;
   localparam logic [63:0] VFEAT [NV] = '{
      64'h00_00_00_00_00_00_00_00,
      64'h00_00_00_10_00_00_41_00,
      64'h00_00_00_11_00_00_41_00,
      64'h11_00_00_00_00_00_00_81,
      64'h00_00_11_00_00_41_00_81,
      64'h00_00_05_00_00_41_00_81,
      64'h00_00_00_00_20_00_00_80,
      64'h10_00_00_00_00_40_00_81,
      64'hFF_FF_FF_FF_00_FF_00_00
   };
   localparam logic VEXP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

   task automatic check(input string req, input logic act, input logic exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic wr_node(input int idx, input logic inv, input logic [2:0] sel,
                          input logic [7:0] thr);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 3'(idx);
      wr_data = {inv, sel, thr};   // R7 field layout
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wr_leaf(input logic [7:0] bits);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 3'd7;
      wr_data = {4'h0, bits};
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Drive one frame; returns at the negedge after the capturing edge.
   task automatic do_frame(input logic [63:0] f);
      @(negedge clk);
      feat  = f;
      frame = 1'b1;
      @(negedge clk);
      frame = 1'b0;
   endtask

   task automatic program_a();
      wr_node(0, 1'b0, 3'd0, 8'h80);
      wr_node(1, 1'b0, 3'd1, 8'h40);
      wr_node(2, 1'b1, 3'd2, 8'h40);
      wr_node(3, 1'b0, 3'd3, 8'h10);
      wr_node(4, 1'b0, 3'd4, 8'h10);
      wr_node(5, 1'b0, 3'd5, 8'h10);
      wr_node(6, 1'b0, 3'd7, 8'h10);
      wr_leaf(8'h96);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL R2 watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      frame = 1'b0; feat = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", valid, 1'b0);
      check("R1 class after reset", cls, 1'b0);

      // R1: all-zero config; every node goes right, leaf 7 class is 0
      do_frame(64'hFFFF_FFFF_FFFF_FFFF);
      check("R2 valid after frame", valid, 1'b1);
      check("R1 default leaf class", cls, 1'b0);
      @(negedge clk);
      check("R2 valid drops", valid, 1'b0);

      program_a();
      for (int i = 0; i < NV; i++) begin
         do_frame(VFEAT[i]);
         check($sformatf("R3 R4 R5 R6 R7 R10 vector %0d", i), cls, VEXP[i]);
         check($sformatf("R2 vector %0d valid", i), valid, 1'b1);
      end

      // R9: class holds between frames despite feature and leaf changes
      do_frame(VFEAT[1]);
      feat = VFEAT[0];
      wr_leaf(8'h00);
      repeat (2) @(negedge clk);
      check("R9 class held", cls, 1'b1);
      check("R2 no strobe without frame", valid, 1'b0);
      wr_leaf(8'h96);

      // R8: write coinciding with frame applies only from next frame
      @(negedge clk);
      feat    = VFEAT[1];
      frame   = 1'b1;
      wr_en   = 1'b1;
      wr_addr = 3'd7;
      wr_data = 12'h000;
      @(negedge clk);
      frame = 1'b0;
      wr_en = 1'b0;
      check("R8 same-cycle write ignored", cls, 1'b1);
      do_frame(VFEAT[1]);
      check("R8 write applies next frame", cls, 1'b0);
      wr_leaf(8'h96);

      // R5: node 0 selects feature 6; path right to node 2, node 6, leaf 7
      wr_node(0, 1'b0, 3'd6, 8'h80);
      do_frame(64'h11_81_00_00_00_00_00_00);
      check("R5 select feature 6", cls, 1'b1);

      // R4: invert on root flips path to node 1 -> node 3 -> leaf 0
      wr_node(0, 1'b1, 3'd6, 8'h80);
      do_frame(64'h11_81_00_00_00_00_00_00);
      check("R4 root inverted", cls, 1'b0);

      // R3: equal to threshold with invert set counts as not exceeding, then flipped
      do_frame(64'h11_80_00_00_00_00_00_00);
      check("R3 tie under invert", cls, 1'b1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule